// File: doc/BRIEF.md
# Receiver Status Register Bank

This block gathers the status values that a cable demodulator and its error-correction decoder produce, and places them on a small byte-wide register bus for a host controller. It keeps a 7-bit count of packets the decoder could not correct. The count stops at its ceiling and is cleared only by a master reset or by an explicit clear command. It also keeps a 20-bit bit-error count loaded from a measurement engine. The host reads that count as three bytes, and the bank takes a snapshot of all 20 bits when the low byte is read, so the middle and top bytes always belong to the same value.

The bank also returns the current AGC level, the mean-square error and the signed carrier frequency offset as plain bytes. A fixed identity byte lets software confirm which block it is talking to. A read is one clock cycle long. The read data appears on the clock edge on which the read strobe is sampled, and it holds until the next read.

Top module: `rxStatusBank`

## Requirements
- R1: Each cycle with `uncorPulse` high adds one to the 7-bit uncorrectable-packet count. A read of address 0x13 returns the count in bits 6:0, with bit 7 reading zero.
- R2: Once the count is 0x7F, further pulses leave it at 0x7F.
- R3: The count is set to zero by any of three events: `rstN` low (asynchronous), `softRst` high at a clock edge, or a write of exactly 0x01 to the clear-control address 0x10. A clear write takes priority over an `uncorPulse` in the same cycle, so the count becomes zero.
- R4: Reading address 0x13, however often, does not change the count.
- R5: A cycle with `berValid` high loads `berCount` into the live error count. A read of 0x14 returns bits 7:0 of the live count and copies all 20 bits into a snapshot. A read of 0x15 returns snapshot bits 15:8. A read of 0x16 returns snapshot bits 19:16 in data bits 3:0, with data bits 7:4 reading zero.
- R6: An error-count update after a read of 0x14 does not change what later reads of 0x15 and 0x16 return. Only the next read of 0x14 takes a new snapshot.
- R7: Reads of 0x17, 0x18 and 0x19 return `agcLevel`, `mseLevel` and `freqOffset`, sampled at the read edge, unchanged. This includes negative two's-complement offsets.
- R8: A read of address 0x1A always returns 0x7B.
- R9: A read of any address other than 0x13 to 0x1A returns 0x00. A write to any address other than 0x10 has no effect, and a write to 0x10 of any value other than 0x01 has no effect.
- R10: `regRdData` is 0x00 after a reset. It changes only on a clock edge at which `regRd` is high, and it holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous hard master reset, active low |
| softRst | input | 1 | Synchronous soft master reset, active high |
| uncorPulse | input | 1 | One uncorrectable packet per high cycle |
| berCount | input | 20 | Bit-error count from the measurement engine |
| berValid | input | 1 | Loads `berCount` into the live count |
| agcLevel | input | 8 | AGC gain level, 0x00 = lowest gain |
| mseLevel | input | 8 | Mean-square error of the demodulated signal |
| freqOffset | input | 8 | Carrier frequency offset, two's complement |
| regAddr | input | 8 | Register byte address |
| regRd | input | 1 | Read strobe |
| regWr | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Registered read data |

## Verification
Assertions check several properties on every cycle:
- the count never moves backwards unless it is cleared, and it holds once it reaches 0x7F;
- a clear strobe always leaves zero behind;
- the snapshot changes only on a low-byte read;
- the read data holds between reads, and the identity address always yields 0x7B.

Other behaviours show only in the bench's scenarios:
- that each pulse adds exactly one;
- that the address map returns the right byte at each of the 256 addresses;
- that writes to the wrong address or with the wrong value do nothing;
- that a count update between byte reads does not tear the value.

// File: rtl/rx_status_pkg.sv
package rx_status_pkg;

  localparam logic [7:0] ADDR_CLEAR  = 8'h10;
  localparam logic [7:0] ADDR_UNCOR  = 8'h13;
  localparam logic [7:0] ADDR_BER_LO = 8'h14;
  localparam logic [7:0] ADDR_BER_MI = 8'h15;
  localparam logic [7:0] ADDR_BER_HI = 8'h16;
  localparam logic [7:0] ADDR_AGC    = 8'h17;
  localparam logic [7:0] ADDR_MSE    = 8'h18;
  localparam logic [7:0] ADDR_FOFS   = 8'h19;
  localparam logic [7:0] ADDR_IDENT  = 8'h1A;

  localparam logic [7:0] IDENT_VALUE = 8'h7B;
  localparam logic [7:0] CLEAR_KEY   = 8'h01;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_UNCOR,
    SEL_BER_LO,
    SEL_BER_MI,
    SEL_BER_HI,
    SEL_AGC,
    SEL_MSE,
    SEL_FOFS,
    SEL_IDENT
  } regSel_t;

  typedef struct packed {
    logic    clearUncor;
    logic    latchBer;
    logic    readEn;
    regSel_t sel;
  } ctlStrobes_t;

endpackage

// File: rtl/rxStatusCtl.sv
module rxStatusCtl
  import rx_status_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWrData,
  output ctlStrobes_t       strobes
);

  regSel_t decodedSel;

  // Address decode; anything outside the map selects nothing (reads as zero).
  always_comb begin
    unique case (regAddr)
      ADDR_UNCOR:  decodedSel = SEL_UNCOR;
      ADDR_BER_LO: decodedSel = SEL_BER_LO;
      ADDR_BER_MI: decodedSel = SEL_BER_MI;
      ADDR_BER_HI: decodedSel = SEL_BER_HI;
      ADDR_AGC:    decodedSel = SEL_AGC;
      ADDR_MSE:    decodedSel = SEL_MSE;
      ADDR_FOFS:   decodedSel = SEL_FOFS;
      ADDR_IDENT:  decodedSel = SEL_IDENT;
      default:     decodedSel = SEL_NONE;
    endcase
  end

  always_comb begin
    strobes.readEn     = regRd;
    strobes.sel        = decodedSel;
    strobes.latchBer   = regRd && (decodedSel == SEL_BER_LO);
    strobes.clearUncor = regWr && (regAddr == ADDR_CLEAR)
                         && (regWrData == CLEAR_KEY);
  end

endmodule

// File: rtl/rxStatusDp.sv
module rxStatusDp
  import rx_status_pkg::*;
#(
  parameter int CNT_W  = 7,
  parameter int BER_W  = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic              uncorPulse,
  input  logic [BER_W-1:0]  berCount,
  input  logic              berValid,
  input  logic [DATA_W-1:0] agcLevel,
  input  logic [DATA_W-1:0] mseLevel,
  input  logic [DATA_W-1:0] freqOffset,
  input  ctlStrobes_t       strobes,
  output logic [DATA_W-1:0] regRdData
);

  localparam int TOP_W = BER_W - 2*DATA_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0]  uncorCnt;
  logic [BER_W-1:0]  berLive;
  logic [BER_W-1:0]  berShadow;
  logic [DATA_W-1:0] readMux;

  // Saturating packet counter; clear wins over a coincident pulse.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      uncorCnt <= '0;
    end else if (softRst || strobes.clearUncor) begin
      uncorCnt <= '0;
    end else if (uncorPulse && (uncorCnt != CNT_MAX)) begin
      uncorCnt <= uncorCnt + 1'b1;
    end
  end

  // Live error count and the snapshot taken on a low-byte read.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      berLive   <= '0;
      berShadow <= '0;
    end else if (softRst) begin
      berLive   <= '0;
      berShadow <= '0;
    end else begin
      if (berValid)         berLive   <= berCount;
      if (strobes.latchBer) berShadow <= berLive;
    end
  end

  always_comb begin
    unique case (strobes.sel)
      SEL_UNCOR:  readMux = {{(DATA_W-CNT_W){1'b0}}, uncorCnt};
      SEL_BER_LO: readMux = berLive[DATA_W-1:0];
      SEL_BER_MI: readMux = berShadow[2*DATA_W-1:DATA_W];
      SEL_BER_HI: readMux = {{(DATA_W-TOP_W){1'b0}}, berShadow[BER_W-1:2*DATA_W]};
      SEL_AGC:    readMux = agcLevel;
      SEL_MSE:    readMux = mseLevel;
      SEL_FOFS:   readMux = freqOffset;
      SEL_IDENT:  readMux = IDENT_VALUE;
      default:    readMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRdData <= '0;
    end else if (softRst) begin
      regRdData <= '0;
    end else if (strobes.readEn) begin
      regRdData <= readMux;
    end
  end

  // R1: without a clear the count never moves backwards
  assert_no_decrement_R1: assert property (@(posedge clk) disable iff (!rstN || softRst)
    !strobes.clearUncor |=> uncorCnt >= $past(uncorCnt));

  // R2: ceiling is sticky
  assert_sat_hold_R2: assert property (@(posedge clk) disable iff (!rstN || softRst)
    (uncorCnt == CNT_MAX && !strobes.clearUncor) |=> uncorCnt == CNT_MAX);

  // R3: clear strobe always leaves zero, even with a pulse
  assert_clear_wins_R3: assert property (@(posedge clk) disable iff (!rstN || softRst)
    strobes.clearUncor |=> uncorCnt == '0);

  // R6: snapshot changes only on a low-byte read
  assert_shadow_stable_R6: assert property (@(posedge clk) disable iff (!rstN || softRst)
    !strobes.latchBer |=> $stable(berShadow));

  // R8: identity reads constant
  assert_ident_value_R8: assert property (@(posedge clk) disable iff (!rstN || softRst)
    (strobes.readEn && strobes.sel == SEL_IDENT) |=> regRdData == IDENT_VALUE);

  // R10: read data holds between reads
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rstN || softRst)
    !strobes.readEn |=> $stable(regRdData));

endmodule

// File: rtl/rxStatusBank.sv
module rxStatusBank
  import rx_status_pkg::*;
#(
  parameter int CNT_W  = 7,
  parameter int BER_W  = 20,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic              uncorPulse,
  input  logic [BER_W-1:0]  berCount,
  input  logic              berValid,
  input  logic [DATA_W-1:0] agcLevel,
  input  logic [DATA_W-1:0] mseLevel,
  input  logic [DATA_W-1:0] freqOffset,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData
);

  ctlStrobes_t strobes;

  rxStatusCtl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctl (
    .regAddr   (regAddr),
    .regRd     (regRd),
    .regWr     (regWr),
    .regWrData (regWrData),
    .strobes   (strobes)
  );

  rxStatusDp #(.CNT_W(CNT_W), .BER_W(BER_W), .DATA_W(DATA_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .softRst    (softRst),
    .uncorPulse (uncorPulse),
    .berCount   (berCount),
    .berValid   (berValid),
    .agcLevel   (agcLevel),
    .mseLevel   (mseLevel),
    .freqOffset (freqOffset),
    .strobes    (strobes),
    .regRdData  (regRdData)
  );

endmodule

// File: tb/test_rxStatusBank.sv
module test_rxStatusBank;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        softRst = 1'b0;
  logic        uncorPulse = 1'b0;
  logic [19:0] berCount = '0;
  logic        berValid = 1'b0;
  logic [7:0]  agcLevel = 8'h00;
  logic [7:0]  mseLevel = 8'h00;
  logic [7:0]  freqOffset = 8'h00;
  logic [7:0]  regAddr = 8'h00;
  logic        regRd = 1'b0;
  logic        regWr = 1'b0;
  logic [7:0]  regWrData = 8'h00;
  logic [7:0]  regRdData;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // bench model state
  int          mCnt = 0;
  logic [19:0] mLive = '0;
  logic [19:0] mShadow = '0;

  rxStatusBank i_rxStatusBank (
    .clk(clk), .rstN(rstN), .softRst(softRst), .uncorPulse(uncorPulse),
    .berCount(berCount), .berValid(berValid), .agcLevel(agcLevel),
    .mseLevel(mseLevel), .freqOffset(freqOffset), .regAddr(regAddr),
    .regRd(regRd), .regWr(regWr), .regWrData(regWrData), .regRdData(regRdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [7:0] a);
    case (a)
      8'h13:   return 8'(mCnt);
      8'h14:   return mLive[7:0];
      8'h15:   return mShadow[15:8];
      8'h16:   return {4'h0, mShadow[19:16]};
      8'h17:   return agcLevel;
      8'h18:   return mseLevel;
      8'h19:   return freqOffset;
      8'h1A:   return 8'h7B;
      default: return 8'h00;
    endcase
  endfunction

  task automatic readCheck(input logic [7:0] a, input string tag);
    logic [7:0] exp;
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    exp = expRead(a);
    if (a == 8'h14) mShadow = mLive;
    @(negedge clk);
    regRd = 1'b0;
    check(tag, regRdData, exp);
  endtask

  task automatic pulse();
    @(negedge clk);
    uncorPulse = 1'b1;
    @(negedge clk);
    uncorPulse = 1'b0;
    if (mCnt < 127) mCnt++;
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWr = 1'b1; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
    if (a == 8'h10 && d == 8'h01) mCnt = 0;
  endtask

  task automatic loadBer(input logic [19:0] v);
    @(negedge clk);
    berCount = v; berValid = 1'b1;
    @(negedge clk);
    berValid = 1'b0;
    mLive = v;
  endtask

  task automatic modelReset();
    mCnt = 0; mLive = '0; mShadow = '0;
  endtask

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        errors++;
        $display("FAIL watchdog: run hung");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    check("R10 reset read data", regRdData, 8'h00);
    rstN = 1'b1;
    readCheck(8'h13, "R3 count zero after hard reset");
    readCheck(8'h16, "R5 top byte zero after reset");

    // R1/R2: sweep the counter through its ceiling
    for (int k = 1; k <= 135; k++) begin
      pulse();
      readCheck(8'h13, (k > 127) ? "R2 saturated count" : "R1 count increment");
    end

    // R4: repeated reads leave the count alone
    for (int k = 0; k < 5; k++) readCheck(8'h13, "R4 read does not clear");

    // R9: writes elsewhere or with the wrong value are ignored
    for (int a = 0; a < 256; a++) begin
      if (a != 8'h10) writeReg(8'(a), 8'h01);
    end
    writeReg(8'h10, 8'hFF);
    writeReg(8'h10, 8'h00);
    writeReg(8'h10, 8'h03);
    readCheck(8'h13, "R9 ignored writes keep count");

    // R3: clear command
    writeReg(8'h10, 8'h01);
    readCheck(8'h13, "R3 clear write");
    for (int k = 0; k < 10; k++) pulse();
    readCheck(8'h13, "R1 count after clear");

    // R3: clear and pulse together, clear wins
    @(negedge clk);
    uncorPulse = 1'b1; regWr = 1'b1; regAddr = 8'h10; regWrData = 8'h01;
    @(negedge clk);
    uncorPulse = 1'b0; regWr = 1'b0;
    mCnt = 0;
    readCheck(8'h13, "R3 clear beats pulse");

    // R3: soft reset
    for (int k = 0; k < 4; k++) pulse();
    loadBer(20'hABCDE);
    @(negedge clk); softRst = 1'b1;
    @(negedge clk); softRst = 1'b0;
    modelReset();
    check("R10 read data after soft reset", regRdData, 8'h00);
    readCheck(8'h13, "R3 count after soft reset");
    readCheck(8'h14, "R3 error count after soft reset");

    // R5: walking ones and assorted values through the three bytes
    for (int i = 0; i < 24; i++) begin
      logic [19:0] v;
      v = (i < 20) ? (20'h1 << i) : 20'((i * 20'h2F1B3) ^ 20'h5A5A5);
      loadBer(v);
      readCheck(8'h14, "R5 low byte");
      readCheck(8'h15, "R5 middle byte");
      readCheck(8'h16, "R5 top nibble");
    end

    // R6: update between byte reads does not tear
    loadBer(20'hF1234);
    readCheck(8'h14, "R6 low byte before update");
    loadBer(20'h0ABCD);
    readCheck(8'h15, "R6 middle from snapshot");
    readCheck(8'h16, "R6 top from snapshot");
    readCheck(8'h14, "R6 new low byte");
    readCheck(8'h16, "R6 new top after new snapshot");

    // R7/R8/R9: full address sweep with several measurement patterns
    for (int p = 0; p < 3; p++) begin
      agcLevel   = 8'(8'h11 + p * 8'h70);
      mseLevel   = 8'(8'h3C ^ (p * 8'h55));
      freqOffset = (p == 0) ? 8'h80 : ((p == 1) ? 8'hFF : 8'h7F);
      for (int a = 0; a < 256; a++) begin
        if (a >= 8'h17 && a <= 8'h19)      readCheck(8'(a), "R7 measurement byte");
        else if (a == 8'h1A)               readCheck(8'(a), "R8 identity");
        else if (a >= 8'h13 && a <= 8'h16) readCheck(8'(a), "R5 map sweep");
        else                               readCheck(8'(a), "R9 unmapped read");
      end
    end

    // R10: data holds while no read is issued
    readCheck(8'h1A, "R8 identity before hold");
    held = regRdData;
    regAddr = 8'h17;
    agcLevel = 8'h5E;
    repeat (3) @(negedge clk);
    check("R10 data holds without read", regRdData, held);

    // R3: asynchronous hard reset mid-run
    for (int k = 0; k < 3; k++) pulse();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    modelReset();
    readCheck(8'h13, "R3 count after hard reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule